// File: doc/BRIEF.md
# Interrupt Priority Resolver with Rotation and End-of-Service Handling

This block keeps the pending-request, in-service and mask state for eight interrupt lines. It resolves which line should be served next. Requests are captured either on a rising edge or as a live level, depending on a configuration input. Masked lines are left out of the contest. An interrupt output is raised only when the best unmasked pending line outranks every line already being served.

Priority is counted from a movable base. One level is marked as the lowest, and the level just after it, counting upward and wrapping, is the highest. After reset the lowest is level 7, which gives plain fixed order with line 0 first.

The base can be moved in three ways:
- by an explicit set-lowest command;
- by combining it with an end-of-service command;
- automatically after each service, when automatic end-of-service is configured.

Acknowledge works as a pair of strobes. The first strobe marks the winning line as in service and drops its latched edge request. The closing strobe releases the line when automatic end-of-service is selected. Bus decoding lives outside this block. It feeds in already decoded command pulses and fields.

Top module: `irq_prio_core`

## Requirements
- R1: After reset the pending, in-service and mask registers read 0, the lowest-priority level reads 7 and the interrupt output is low.
- R2: In edge mode a 0-to-1 change on a request line sets its pending bit one clock later. The bit stays set while the line stays high. It is cleared by the acknowledge that serves that line, and is not set again until a new rising edge.
- R3: In level mode each pending bit equals the request line as sampled on the previous clock.
- R4: A line whose mask bit is 1 is still recorded as pending, but never wins and never raises the interrupt output. A mask write takes effect on the next clock.
- R5: The winner is the unmasked pending line nearest above the lowest level, counting upward with wrap. With the reset base, line 0 wins over every other line.
- R6: The interrupt output is high only if the winner ranks strictly above every in-service line under the current base.
- R7: A first acknowledge strobe while a winner exists sets that line's in-service bit on the next clock.
- R8: Command code {rotate,select,eoi} = 001 clears the highest-ranked in-service bit.
- R9: Command code 011 clears the in-service bit of the given level field.
- R10: Command code 101 clears the highest-ranked in-service bit and makes that level lowest. Code 111 clears the given level and makes it lowest. Code 110 only makes the given level lowest.
- R11: With automatic end-of-service configured, the closing acknowledge strobe clears the in-service bit set by the preceding first strobe, without any command.
- R12: Code 100 arms, and code 000 disarms, automatic rotation. While it is armed in automatic end-of-service mode, each closing strobe makes the served level lowest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_level | input | 1 | 1: level-sensitive requests, 0: rising-edge requests |
| cfg_aeoi | input | 1 | 1: closing acknowledge strobe ends service automatically |
| irq_in | input | 8 | Request lines |
| mask_wr | input | 1 | Load pulse for the mask register |
| mask_val | input | 8 | New mask value, 1 = blocked |
| pcmd_wr | input | 1 | Priority/end-of-service command pulse |
| pcmd_r | input | 1 | Command rotate field |
| pcmd_sl | input | 1 | Command select-level field |
| pcmd_eoi | input | 1 | Command end-of-service field |
| pcmd_lvl | input | 3 | Command level field |
| ack_set | input | 1 | First acknowledge strobe |
| ack_done | input | 1 | Closing acknowledge strobe |
| int_req | output | 1 | Interrupt request to the processor |
| win_id | output | 3 | Number of the winning line |
| irr_q | output | 8 | Pending register read-back |
| isr_q | output | 8 | In-service register read-back |
| imr_q | output | 8 | Mask register read-back |
| prio_low | output | 3 | Current lowest-priority level |

## Verification
The assertions assume that a first acknowledge strobe, a closing strobe and a command pulse do not fall in the same cycle. Where they could collide, the properties exclude that case explicitly. The assertions also assume that a closing strobe always follows a first strobe, so the remembered served level is meaningful. The directed stimulus issues every pulse for exactly one cycle and keeps them apart. It changes request lines only in cycles without an acknowledge, and it never acknowledges while no unmasked line is pending.

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_level,
  input  logic         cfg_aeoi,
  input  logic [N-1:0] irq_in,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_val,
  input  logic         pcmd_wr,
  input  logic         pcmd_r,
  input  logic         pcmd_sl,
  input  logic         pcmd_eoi,
  input  logic [W-1:0] pcmd_lvl,
  input  logic         ack_set,
  input  logic         ack_done,
  output logic         int_req,
  output logic [W-1:0] win_id,
  output logic [N-1:0] irr_q,
  output logic [N-1:0] isr_q,
  output logic [N-1:0] imr_q,
  output logic [W-1:0] prio_low
);
  localparam logic [N-1:0] ONE  = {{(N-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

  logic [N-1:0] irq_prev;
  logic [W-1:0] svc_q;
  logic         rot_aeoi_q;
  logic         req_hit, isr_hit;
  logic [W-1:0] req_id, isr_id;

  function automatic logic [W-1:0] rank_of(input logic [W-1:0] id, input logic [W-1:0] low);
    return id - low - STEP;
  endfunction

  wire [N-1:0] pend = irr_q & ~imr_q;

  always_comb begin
    req_hit = 1'b0;
    req_id  = '0;
    isr_hit = 1'b0;
    isr_id  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      logic [W-1:0] idx;
      idx = prio_low + STEP + W'(k);
      if (pend[idx])  begin req_hit = 1'b1; req_id = idx; end
      if (isr_q[idx]) begin isr_hit = 1'b1; isr_id = idx; end
    end
  end

  assign win_id  = req_id;
  assign int_req = req_hit & (~isr_hit | (rank_of(req_id, prio_low) < rank_of(isr_id, prio_low)));

  wire           take     = ack_set & req_hit;
  wire [W-1:0]   eoi_lvl  = pcmd_sl ? pcmd_lvl : isr_id;
  wire           lvl_ok   = pcmd_sl | isr_hit;
  wire           cmd_eoi  = pcmd_wr & pcmd_eoi & lvl_ok;
  wire           cmd_rot  = pcmd_wr & pcmd_r & (pcmd_sl | pcmd_eoi) & lvl_ok;
  wire           cmd_arm  = pcmd_wr & ~pcmd_sl & ~pcmd_eoi;
  wire           auto_end = ack_done & cfg_aeoi;
  wire           auto_rot = auto_end & rot_aeoi_q;

  wire [N-1:0] clr_cmd  = cmd_eoi  ? (ONE << eoi_lvl) : '0;
  wire [N-1:0] clr_auto = auto_end ? (ONE << svc_q)   : '0;
  wire [N-1:0] set_ack  = take     ? (ONE << req_id)  : '0;
  wire [N-1:0] clr_irr  = (take & ~cfg_level) ? (ONE << req_id) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_prev   <= '0;
      irr_q      <= '0;
      isr_q      <= '0;
      imr_q      <= '0;
      prio_low   <= W'(N - 1);
      svc_q      <= '0;
      rot_aeoi_q <= 1'b0;
    end else begin
      irq_prev <= irq_in;
      if (cfg_level) irr_q <= irq_in;
      else           irr_q <= (irr_q | (irq_in & ~irq_prev)) & ~clr_irr;
      isr_q <= (isr_q & ~clr_cmd & ~clr_auto) | set_ack;
      if (mask_wr) imr_q <= mask_val;
      if (take)    svc_q <= req_id;
      if (cmd_arm) rot_aeoi_q <= pcmd_r;
      if (cmd_rot)       prio_low <= eoi_lvl;
      else if (auto_rot) prio_low <= svc_q;
    end
  end

  assert_masked_never_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> !imr_q[win_id]);

  assert_int_outranks_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> !isr_q[win_id]);

  assert_ack_marks_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_set && req_hit && !pcmd_wr && !ack_done) |=> isr_q[$past(win_id)]);

  assert_nseoi_clears_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pcmd_wr && !pcmd_r && !pcmd_sl && pcmd_eoi && isr_q != '0 && !ack_set && !ack_done)
      |=> $countones(isr_q) == $countones($past(isr_q)) - 1);

  assert_set_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pcmd_wr && pcmd_r && pcmd_sl) |=> prio_low == $past(pcmd_lvl));

  assert_auto_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done && cfg_aeoi && !ack_set) |=> !isr_q[$past(svc_q)]);
endmodule

// File: tb/sim_irq_prio_core.sv
module sim_irq_prio_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_level = 1'b0, cfg_aeoi = 1'b0;
  logic [7:0] irq_in = '0;
  logic       mask_wr = 1'b0;
  logic [7:0] mask_val = '0;
  logic       pcmd_wr = 1'b0, pcmd_r = 1'b0, pcmd_sl = 1'b0, pcmd_eoi = 1'b0;
  logic [2:0] pcmd_lvl = '0;
  logic       ack_set = 1'b0, ack_done = 1'b0;
  logic       int_req;
  logic [2:0] win_id, prio_low;
  logic [7:0] irr_q, isr_q, imr_q;

  int checks = 0;
  int fails = 0;

  irq_prio_core u0 (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_aeoi(cfg_aeoi),
    .irq_in(irq_in), .mask_wr(mask_wr), .mask_val(mask_val),
    .pcmd_wr(pcmd_wr), .pcmd_r(pcmd_r), .pcmd_sl(pcmd_sl), .pcmd_eoi(pcmd_eoi),
    .pcmd_lvl(pcmd_lvl), .ack_set(ack_set), .ack_done(ack_done),
    .int_req(int_req), .win_id(win_id), .irr_q(irr_q), .isr_q(isr_q),
    .imr_q(imr_q), .prio_low(prio_low)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic lvl, input logic aeoi);
    rst_n = 1'b0; cfg_level = lvl; cfg_aeoi = aeoi; irq_in = '0;
    repeat (2) cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic send_cmd(input logic [2:0] op, input logic [2:0] lvl);
    {pcmd_r, pcmd_sl, pcmd_eoi} = op; pcmd_lvl = lvl; pcmd_wr = 1'b1;
    cyc();
    pcmd_wr = 1'b0;
  endtask

  task automatic do_ack();
    ack_set = 1'b1; cyc(); ack_set = 1'b0;
  endtask

  task automatic do_done();
    ack_done = 1'b1; cyc(); ack_done = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0);
    check("R1 irr", irr_q, 0);
    check("R1 isr", isr_q, 0);
    check("R1 imr", imr_q, 0);
    check("R1 low", prio_low, 7);
    check("R1 int", int_req, 0);
  endtask

  task automatic t_nested();
    do_reset(1'b0, 1'b0);
    irq_in = 8'h24; cyc();
    check("R2 capture", irr_q, 8'h24);
    check("R5 winner", win_id, 2);
    check("R6 int idle", int_req, 1);
    do_ack();
    check("R7 isr set", isr_q, 8'h04);
    check("R2 cleared by ack", irr_q, 8'h20);
    check("R6 lower blocked", int_req, 0);
    cyc();
    check("R2 no recapture while high", irr_q, 8'h20);
    irq_in = 8'h26; cyc();
    check("R5 new winner", win_id, 1);
    check("R6 higher passes", int_req, 1);
    do_ack();
    check("R7 nested isr", isr_q, 8'h06);
    send_cmd(3'b001, 3'd0);
    check("R8 nseoi", isr_q, 8'h04);
    send_cmd(3'b011, 3'd2);
    check("R9 specific eoi", isr_q, 8'h00);
    check("R6 pending 5", int_req, 1);
    check("R5 winner 5", win_id, 5);
    irq_in = '0;
  endtask

  task automatic t_mask();
    do_reset(1'b0, 1'b0);
    mask_val = 8'h08; mask_wr = 1'b1; cyc(); mask_wr = 1'b0;
    check("R4 mask read", imr_q, 8'h08);
    irq_in = 8'h08; cyc();
    check("R4 masked recorded", irr_q, 8'h08);
    check("R4 masked no int", int_req, 0);
    irq_in = 8'h48; cyc();
    check("R4 other wins", win_id, 6);
    check("R4 other int", int_req, 1);
    mask_val = 8'h00; mask_wr = 1'b1; cyc(); mask_wr = 1'b0;
    check("R4 unmask winner", win_id, 3);
    irq_in = '0;
  endtask

  task automatic t_level();
    do_reset(1'b1, 1'b0);
    irq_in = 8'h10; cyc();
    check("R3 follow high", irr_q, 8'h10);
    irq_in = 8'h00; cyc();
    check("R3 follow low", irr_q, 8'h00);
  endtask

  task automatic t_rotate();
    do_reset(1'b0, 1'b0);
    send_cmd(3'b110, 3'd4);
    check("R10 set lowest", prio_low, 4);
    irq_in = 8'h44; cyc();
    check("R10 rotated winner", win_id, 6);
    do_ack();
    check("R10 isr 6", isr_q, 8'h40);
    send_cmd(3'b101, 3'd0);
    check("R10 rot nseoi isr", isr_q, 8'h00);
    check("R10 rot nseoi low", prio_low, 6);
    check("R10 winner after", win_id, 2);
    send_cmd(3'b111, 3'd1);
    check("R10 rot specific low", prio_low, 1);
    irq_in = '0;
  endtask

  task automatic t_aeoi();
    do_reset(1'b0, 1'b1);
    irq_in = 8'h08; cyc();
    do_ack();
    check("R11 isr set", isr_q, 8'h08);
    do_done();
    check("R11 auto clear", isr_q, 8'h00);
    check("R11 no rotate", prio_low, 7);
    send_cmd(3'b100, 3'd0);
    irq_in = 8'h28; cyc();
    do_ack();
    do_done();
    check("R12 auto rotate", prio_low, 5);
    check("R12 isr clear", isr_q, 8'h00);
    send_cmd(3'b000, 3'd0);
    irq_in = 8'h2A; cyc();
    do_ack();
    do_done();
    check("R12 disarmed", prio_low, 5);
    irq_in = '0;
  endtask

  initial begin
    #(20 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc();
    t_reset();
    t_nested();
    t_mask();
    t_level();
    t_rotate();
    t_aeoi();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule